// File: doc/BRIEF.md
# Instruction Bundle Template Decoder

This block sits at the front of an in-order issue path. Each cycle it can take one 128-bit instruction bundle, pull out the 5-bit template field and the three 41-bit instruction slots, and decode the template. The decode gives the functional-unit class that each slot needs, which slots hold a real operation, and where the instruction-group boundaries fall. A group boundary separates runs of operations that the issue logic may start together.

Template codes come in pairs. The odd member of each pair adds a boundary after the last slot. Two layouts also place a boundary inside the bundle. The long-immediate layout joins slots 1 and 2 into one operation. Codes that are not assigned raise an illegal flag and mark no slot as valid. Results are held in one output register stage with a valid/ready handshake. When the consumer keeps ready high, the block accepts a bundle every cycle.

Top module: `bundle_decoder`

## Requirements
- R1: Bits [4:0] of `in_bundle` are the template code. Slot k sits at `in_bundle[5+41k +: 41]`. The slot is passed unchanged to `out_slots[41k +: 41]`.
- R2: Unit codes are none=0, memory=1, integer=2, float=3, branch=4, long=5. Slot k's code is on `out_unit[3k +: 3]`. The non-branch layouts give these units for slots 0/1/2: codes 0-3 memory/integer/integer, 8-11 memory/memory/integer, 12-13 memory/float/integer, 14-15 memory/memory/float. Each of these sets `out_slot_vld`=3'b111.
- R3: The branch layouts give these units for slots 0/1/2: codes 16-17 memory/integer/branch, 18-19 memory/memory/branch, 22-23 branch/branch/branch, 24-25 memory/branch/branch, 28-29 memory/float/branch. Each of these sets `out_slot_vld`=3'b111.
- R4: Codes 4-5 are the long-immediate layout. They give memory in slot 0, long (5) in slot 1 and none (0) in slot 2, with `out_slot_vld`=3'b011.
- R5: For a legal code, `out_stop[2]` (a boundary after slot 2) equals bit 0 of the code.
- R6: `out_stop[1]` is set only for codes 2-3. `out_stop[0]` is set only for codes 10-11.
- R7: Codes 6, 7, 20, 21, 26, 27, 30 and 31 set `out_illegal`=1 and give `out_slot_vld`=0, `out_stop`=0 and all units none. Legal codes give `out_illegal`=0.
- R8: A bundle is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its results and `out_valid`=1 appear right after that edge. If no bundle is accepted and `out_ready` is high, `out_valid` falls after the edge.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all outputs hold their values.
- R10: While `rst` is high, `out_valid` is driven to 0. After reset, `in_ready` is 1.
- R11: With `out_ready` held high, a new bundle is accepted and decoded on every cycle. No bubble appears between bundles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Block can take a bundle |
| in_bundle | input | 128 | Template plus three slots |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_slots | output | 123 | Three raw instruction slots |
| out_unit | output | 9 | Unit class per slot, 3 bits each |
| out_slot_vld | output | 3 | Slot holds a real operation |
| out_stop | output | 3 | Bit k: group boundary after slot k |
| out_illegal | output | 1 | Reserved template code |

## Verification
Every decoded field, the copied slots and `out_valid` are due one rising edge after the accepting edge. The bench drives inputs on the falling edge and reads outputs 1 ns after the next rising edge, so each bundle is checked exactly one cycle after it was offered. During a stall the result must stay unchanged across an edge at which `in_ready` reads 0. The bench checks this, then releases `out_ready` and expects the waiting bundle to appear one edge later. The sweep over all 32 codes runs back to back, so every check in it also confirms the one-per-cycle rate.

// File: rtl/bdec_pkg.sv
`timescale 1ns/1ps
package bdec_pkg;
  localparam int TMPL_W = 5;
  localparam int NSLOT  = 3;
  localparam int UNIT_W = 3;

  typedef enum logic [UNIT_W-1:0] {
    U_NONE = 3'd0,
    U_MEM  = 3'd1,
    U_INT  = 3'd2,
    U_FP   = 3'd3,
    U_BR   = 3'd4,
    U_LONG = 3'd5
  } unit_e;

  function automatic logic [NSLOT*UNIT_W-1:0] pack_units(unit_e s0, unit_e s1, unit_e s2);
    return {s2, s1, s0};
  endfunction
endpackage

// File: rtl/bdec_split.sv
`timescale 1ns/1ps
module bdec_split import bdec_pkg::*; #(
  parameter int SLOT_W = 41,
  localparam int BW = TMPL_W + NSLOT*SLOT_W
) (
  input  logic [BW-1:0]           bundle,
  output logic [TMPL_W-1:0]       tmpl,
  output logic [NSLOT*SLOT_W-1:0] slots
);
  assign tmpl = bundle[TMPL_W-1:0];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign slots[k*SLOT_W +: SLOT_W] = bundle[TMPL_W + k*SLOT_W +: SLOT_W];
  end
endmodule

// File: rtl/bdec_tmpl.sv
`timescale 1ns/1ps
module bdec_tmpl import bdec_pkg::*; (
  input  logic [TMPL_W-1:0]       tmpl,
  output logic [NSLOT*UNIT_W-1:0] units,
  output logic [NSLOT-1:0]        vld,
  output logic [NSLOT-1:0]        stop,
  output logic                    illegal
);
  logic [1:0] mid;

  always_comb begin
    units   = '0;
    vld     = 3'b111;
    mid     = 2'b00;
    illegal = 1'b0;
    case (tmpl[4:1])
      4'd0:  units = pack_units(U_MEM, U_INT, U_INT);
      4'd1:  begin units = pack_units(U_MEM, U_INT, U_INT); mid = 2'b10; end
      4'd2:  begin units = pack_units(U_MEM, U_LONG, U_NONE); vld = 3'b011; end
      4'd4:  units = pack_units(U_MEM, U_MEM, U_INT);
      4'd5:  begin units = pack_units(U_MEM, U_MEM, U_INT); mid = 2'b01; end
      4'd6:  units = pack_units(U_MEM, U_FP,  U_INT);
      4'd7:  units = pack_units(U_MEM, U_MEM, U_FP);
      4'd8:  units = pack_units(U_MEM, U_INT, U_BR);
      4'd9:  units = pack_units(U_MEM, U_MEM, U_BR);
      4'd11: units = pack_units(U_BR,  U_BR,  U_BR);
      4'd12: units = pack_units(U_MEM, U_BR,  U_BR);
      4'd14: units = pack_units(U_MEM, U_FP,  U_BR);
      default: begin
        vld     = 3'b000;
        illegal = 1'b1;
      end
    endcase
    stop = illegal ? 3'b000 : {tmpl[0], mid};
  end
endmodule

// File: rtl/bdec_stage.sv
`timescale 1ns/1ps
module bdec_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (load)     out_data  <= in_data;
    end
  end
endmodule

// File: rtl/bundle_decoder.sv
`timescale 1ns/1ps
module bundle_decoder import bdec_pkg::*; #(
  parameter int SLOT_W = 41,
  localparam int BW = TMPL_W + NSLOT*SLOT_W,
  localparam int SW = NSLOT*SLOT_W,
  localparam int UW = NSLOT*UNIT_W,
  localparam int DW = SW + UW + 2*NSLOT + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_bundle,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_slots,
  output logic [UW-1:0] out_unit,
  output logic [NSLOT-1:0] out_slot_vld,
  output logic [NSLOT-1:0] out_stop,
  output logic          out_illegal
);
  logic [TMPL_W-1:0] tmpl;
  logic [SW-1:0]     slots;
  logic [UW-1:0]     units;
  logic [NSLOT-1:0]  vld, stop;
  logic              illegal;
  logic [DW-1:0]     d_in, d_out;

  bdec_split #(.SLOT_W(SLOT_W)) u_split (
    .bundle(in_bundle), .tmpl(tmpl), .slots(slots)
  );

  bdec_tmpl u_tmpl (
    .tmpl(tmpl), .units(units), .vld(vld), .stop(stop), .illegal(illegal)
  );

  assign d_in = {slots, units, vld, stop, illegal};

  bdec_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(d_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(d_out)
  );

  assign {out_slots, out_unit, out_slot_vld, out_stop, out_illegal} = d_out;
endmodule

// File: rtl/bundle_decoder_chk.sv
`timescale 1ns/1ps
module bundle_decoder_chk import bdec_pkg::*; #(
  parameter int SLOT_W = 41,
  localparam int BW = TMPL_W + NSLOT*SLOT_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [BW-1:0]           in_bundle,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [NSLOT*SLOT_W-1:0] out_slots,
  input logic [NSLOT*UNIT_W-1:0] out_unit,
  input logic [NSLOT-1:0]        out_slot_vld,
  input logic [NSLOT-1:0]        out_stop,
  input logic                    out_illegal
);
  AST_SLOT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (BW'(out_slots) == ($past(in_bundle) >> TMPL_W))); // R1
  AST_FIRST_SLOT_TYPED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal) |-> (out_unit[UNIT_W-1:0] != U_NONE)); // R2
  AST_LONG_PAIR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_unit[2*UNIT_W-1:UNIT_W] == U_LONG) |->
      (out_slot_vld == 3'b011 && out_unit[3*UNIT_W-1:2*UNIT_W] == U_NONE)); // R4
  AST_RESERVED_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_slot_vld == '0 && out_stop == '0)); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slots) && $stable(out_unit)
      && $stable(out_slot_vld) && $stable(out_stop) && $stable(out_illegal))); // R9
endmodule

bind bundle_decoder bundle_decoder_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bundle(in_bundle),
  .out_valid(out_valid), .out_ready(out_ready), .out_slots(out_slots), .out_unit(out_unit),
  .out_slot_vld(out_slot_vld), .out_stop(out_stop), .out_illegal(out_illegal)
);

// File: tb/sim_bundle_decoder.sv
`timescale 1ns/1ps
module sim_bundle_decoder;
  localparam logic [2:0] N = 3'd0, M = 3'd1, I = 3'd2, F = 3'd3, B = 3'd4, L = 3'd5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, in_valid, in_ready, out_valid, out_ready, out_illegal;
  logic [127:0] in_bundle;
  logic [122:0] out_slots;
  logic [8:0]   out_unit;
  logic [2:0]   out_slot_vld, out_stop;

  int tests = 0, fails = 0;
  bit done = 0;

  bundle_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bundle(in_bundle),
    .out_valid(out_valid), .out_ready(out_ready), .out_slots(out_slots), .out_unit(out_unit),
    .out_slot_vld(out_slot_vld), .out_stop(out_stop), .out_illegal(out_illegal)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [122:0] mk_slots(input int seed);
    logic [40:0] a, b, c;
    a = {9'h0, 32'h1357_0000 + 32'(seed)};
    b = {41'h155_5555_5555} ^ {9'h0, 32'(seed * 7)};
    c = {1'b1, 8'hA5, 32'hF00D_0000 | 32'(seed)};
    return {c, b, a};
  endfunction

  // expected decode from the requirement text
  task automatic expect_for(input logic [4:0] c, output logic [8:0] u,
                            output logic [2:0] v, output logic [2:0] s, output logic il);
    logic [1:0] mid;
    il = 0; v = 3'b111; mid = 2'b00;
    case (c)
      0, 1:   u = {I, I, M};
      2, 3:   begin u = {I, I, M}; mid = 2'b10; end
      4, 5:   begin u = {N, L, M}; v = 3'b011; end
      8, 9:   u = {I, M, M};
      10, 11: begin u = {I, M, M}; mid = 2'b01; end
      12, 13: u = {I, F, M};
      14, 15: u = {F, M, M};
      16, 17: u = {B, I, M};
      18, 19: u = {B, M, M};
      22, 23: u = {B, B, B};
      24, 25: u = {B, B, M};
      28, 29: u = {B, F, M};
      default: begin u = '0; v = '0; il = 1; end
    endcase
    s = il ? 3'b000 : {c[0], mid};
  endtask

  task automatic t_reset;
    rst = 1; in_valid = 0; out_ready = 1; in_bundle = '0;
    repeat (3) @(posedge clk);
    #1 chk("R10 out_valid in reset", 128'(out_valid), 128'd0);
    @(negedge clk) rst = 0;
    @(posedge clk); #1;
    chk("R10 in_ready after reset", 128'(in_ready), 128'd1);
    chk("R10 out_valid after reset", 128'(out_valid), 128'd0);
  endtask

  task automatic t_sweep;
    logic [8:0] u; logic [2:0] v, s; logic il;
    string tag;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      in_valid = 1; out_ready = 1;
      in_bundle = {mk_slots(c), 5'(c)};
      @(posedge clk); #1;
      expect_for(5'(c), u, v, s, il);
      if (il) tag = "R7";
      else if (c == 4 || c == 5) tag = "R4";
      else if (c >= 16) tag = "R3";
      else tag = "R2";
      chk({tag, " unit"}, 128'(out_unit), 128'(u));
      chk({tag, " slot_vld"}, 128'(out_slot_vld), 128'(v));
      chk({tag, " illegal"}, 128'(out_illegal), 128'(il));
      chk(il ? "R7 stop" : "R5 end stop", 128'(out_stop[2]), 128'(s[2]));
      chk(il ? "R7 stop" : "R6 mid stop", 128'(out_stop[1:0]), 128'(s[1:0]));
      chk("R11 back-to-back valid", 128'({out_valid, in_ready}), 128'b11);
      chk("R1 slots", 128'(out_slots), 128'(mk_slots(c)));
    end
    @(negedge clk) in_valid = 0;
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_valid = 1; out_ready = 1; in_bundle = {mk_slots(99), 5'd13};
    @(posedge clk); #1;
    chk("R8 valid one edge later", 128'(out_valid), 128'd1);
    chk("R8 data one edge later", 128'(out_slots), 128'(mk_slots(99)));
    @(negedge clk) in_valid = 0;
    @(posedge clk); #1;
    chk("R8 valid drops", 128'(out_valid), 128'd0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    in_valid = 1; out_ready = 0; in_bundle = {mk_slots(5), 5'd3};
    @(posedge clk); #1;
    chk("R9 first accepted", 128'(out_slots), 128'(mk_slots(5)));
    chk("R9 in_ready low", 128'(in_ready), 128'd0);
    @(negedge clk) in_bundle = {mk_slots(6), 5'd23};
    @(posedge clk); #1;
    chk("R9 slots held", 128'(out_slots), 128'(mk_slots(5)));
    chk("R9 unit held", 128'(out_unit), 128'({I, I, M}));
    chk("R9 stop held", 128'(out_stop), 128'b110);
    @(negedge clk) out_ready = 1;
    @(posedge clk); #1;
    chk("R9 waiting bundle taken", 128'(out_slots), 128'(mk_slots(6)));
    chk("R3 unit after release", 128'(out_unit), 128'({B, B, B}));
    chk("R5 stop after release", 128'(out_stop), 128'b100);
    @(negedge clk) in_valid = 0;
    @(posedge clk);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_latency();
    t_stall();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule